// File: doc/BRIEF.md
# Sensor Code to Engineering Units Converter

This block turns a raw sample code from an on-die monitor into a signed reading in engineering units. A sample enters with a mode bit. In temperature mode the reading is in millidegrees Celsius. It comes from an affine equation with four programmable coefficients: a gain `H`, an offset `G`, a calibration divisor `CAL5` and a clock-dependent correction `J`. The result is limited to a fixed operating range. In voltage mode the reading is in microvolts. It comes from a fixed affine equation scaled by a per-sample factor of one or two.

The temperature path needs a division by a divisor that software can change. A bit-serial restoring divider does this over one cycle per bit of the dividend. The voltage path divides only by a constant power of two and finishes in one cycle. Samples arrive and results leave through valid/ready handshakes. A host write port replaces any coefficient at any time. The coefficients reset to one of two preset sensor families, chosen by a parameter.

Top module: `sensor_code_conv`

## Requirements
- R1: While reset is held and after it is released, `in_ready` is 1 and `out_valid` is 0 until a sample is accepted.
- R2: Only bits [15:0] of `in_raw` take part in the conversion. Upper bits of any value give the same result.
- R3: In temperature mode (`in_volt`=0), the result is G + floor(H·n/CAL5) − floor(H/2) + trunc(J·F/1000000), where n is the code, F is `IP_FREQ_HZ`, H, G and CAL5 are unsigned and J is signed.
- R4: A temperature result is clamped to the range −40000 to 125000.
- R5: With `FAMILY_B`=0, reset loads H=200000, G=60000, J=−100, CAL5=4094. With `FAMILY_B`=1, reset loads H=249400, G=57400, J=0, CAL5=4096.
- R6: In voltage mode (`in_volt`=1), the result is P·(90·n − 245805)/1024 with signed division truncated toward zero, where P is 2 when `in_x2`=1 and 1 otherwise.
- R7: A write with `cfg_we`=1 stores `cfg_wdata` in coefficient H (`cfg_addr`=0), G (1), J (2) or CAL5 (3). It applies from the next accepted sample on, and a sample already being converted is not affected.
- R8: A temperature sample taken while CAL5 is 0 gives the result 125000 with `out_err`=1. Every other result has `out_err`=0.
- R9: While `out_valid`=1 and `out_ready`=0, the result, `out_err` and `out_volt` stay fixed. `in_ready` is 0 from acceptance until the result is taken. `out_volt` repeats the mode of the sample.
- R10: Counted in clock cycles after the accepting edge, a voltage result or a CAL5=0 result is valid after 1 cycle, and any other temperature result after 49 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can accept a sample |
| in_raw | input | 32 | Raw sample word; low 16 bits are the code |
| in_volt | input | 1 | 1 = voltage conversion, 0 = temperature |
| in_x2 | input | 1 | Voltage pre-scaler: 1 = times two |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 2 | Coefficient select: 0 H, 1 G, 2 J, 3 CAL5 |
| cfg_wdata | input | 32 | Coefficient value |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Signed result (millidegrees or microvolts) |
| out_volt | output | 1 | Result is a voltage |
| out_err | output | 1 | Divisor was zero; result saturated |

## Verification
Assertions check four things on every cycle: results held while the consumer stalls, `in_ready` and `out_valid` never high together, every temperature result inside the clamp range, and a zero-divisor result pinned at the upper limit. The arithmetic can only be shown by the bench's scenarios. That covers the truncation direction of both divisions, the frequency correction, the presets of both families, code bits above 16 being ignored, and a coefficient write landing while a conversion is in flight. The bench compares each result with a model built from the equations, across random coefficients and codes, and checks the latency of each path.

// File: rtl/sensor_code_conv.sv
module sensor_code_conv #(
  parameter int CODE_W     = 16,
  parameter int RAW_W      = 32,
  parameter int COEF_W     = 32,
  parameter int OUT_W      = 32,
  parameter int IP_FREQ_HZ = 100000000,
  parameter bit FAMILY_B   = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [RAW_W-1:0]         in_raw,
  input  logic                     in_volt,
  input  logic                     in_x2,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_addr,
  input  logic [COEF_W-1:0]        cfg_wdata,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [OUT_W-1:0]  out_data,
  output logic                     out_volt,
  output logic                     out_err
);
  localparam int PROD_W = COEF_W + CODE_W;
  localparam int CNT_W  = $clog2(PROD_W + 1);
  localparam int SW     = 64;
  localparam logic signed [SW-1:0] TMIN  = -64'sd40000;
  localparam logic signed [SW-1:0] TMAX  = 64'sd125000;
  localparam logic signed [SW-1:0] FREQ  = SW'(IP_FREQ_HZ);
  localparam logic signed [SW-1:0] MEGA  = 64'sd1000000;
  localparam logic [COEF_W-1:0] H0 = FAMILY_B ? COEF_W'(249400) : COEF_W'(200000);
  localparam logic [COEF_W-1:0] G0 = FAMILY_B ? COEF_W'(57400)  : COEF_W'(60000);
  localparam logic [COEF_W-1:0] J0 = FAMILY_B ? COEF_W'(0)      : COEF_W'(-100);
  localparam logic [COEF_W-1:0] C0 = FAMILY_B ? COEF_W'(4096)   : COEF_W'(4094);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} state_t;
  state_t st;

  logic [COEF_W-1:0] h_q, g_q, j_q, c_q, div_q, rem;
  logic [PROD_W-1:0] quo;
  logic [CNT_W-1:0]  cnt;
  logic signed [SW-1:0] off_q;
  logic signed [31:0]   vres_q;
  logic volt_q, err_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      h_q <= H0; g_q <= G0; j_q <= J0; c_q <= C0;
    end else if (cfg_we)
      case (cfg_addr)
        2'd0: h_q <= cfg_wdata;
        2'd1: g_q <= cfg_wdata;
        2'd2: j_q <= cfg_wdata;
        default: c_q <= cfg_wdata;
      endcase

  logic [CODE_W-1:0] code;
  logic unused_raw;
  assign code = in_raw[CODE_W-1:0];
  assign unused_raw = ^in_raw[RAW_W-1:CODE_W];

  logic signed [SW-1:0] jext, corr, off_n;
  assign jext  = SW'($signed(j_q));
  assign corr  = (jext * FREQ) / MEGA;
  assign off_n = $signed(SW'(g_q)) - $signed(SW'(h_q >> 1)) + corr;

  logic signed [31:0] vlin, vsc, vres_n;
  assign vlin   = 32'sd90 * $signed(32'(code)) - 32'sd245805;
  assign vsc    = in_x2 ? (vlin <<< 1) : vlin;
  assign vres_n = vsc / 32'sd1024;

  logic [COEF_W:0] trial;
  logic ge;
  assign trial = {rem, quo[PROD_W-1]};
  assign ge    = trial >= {1'b0, div_q};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; quo <= '0; rem <= '0; div_q <= '0; cnt <= '0;
      off_q <= '0; vres_q <= '0; volt_q <= 1'b0; err_q <= 1'b0;
    end else
      case (st)
        S_IDLE: if (in_valid) begin
          volt_q <= in_volt;
          err_q  <= 1'b0;
          if (in_volt) begin
            vres_q <= vres_n;
            st     <= S_DONE;
          end else if (c_q == '0) begin
            err_q <= 1'b1;
            st    <= S_DONE;
          end else begin
            quo   <= PROD_W'(h_q) * PROD_W'(code);
            rem   <= '0;
            div_q <= c_q;
            off_q <= off_n;
            cnt   <= CNT_W'(PROD_W);
            st    <= S_BUSY;
          end
        end
        S_BUSY: begin
          quo <= {quo[PROD_W-2:0], ge};
          rem <= ge ? COEF_W'(trial - {1'b0, div_q}) : COEF_W'(trial);
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) st <= S_DONE;
        end
        default: if (out_ready) st <= S_IDLE;
      endcase

  logic signed [SW-1:0] tsum, tres;
  assign tsum = off_q + $signed(SW'(quo));
  assign tres = (tsum < TMIN) ? TMIN : (tsum > TMAX) ? TMAX : tsum;

  assign in_ready  = st == S_IDLE;
  assign out_valid = st == S_DONE;
  assign out_volt  = volt_q;
  assign out_err   = err_q;
  assign out_data  = volt_q ? OUT_W'(vres_q) : err_q ? OUT_W'(TMAX) : OUT_W'(tres);
endmodule

// File: rtl/sensor_code_conv_chk.sv
module sensor_code_conv_chk #(
  parameter int OUT_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [OUT_W-1:0] out_data,
  input logic                    out_volt,
  input logic                    out_err
);
  localparam logic signed [OUT_W-1:0] TMIN = -OUT_W'(40000);
  localparam logic signed [OUT_W-1:0] TMAX = OUT_W'(125000);

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> in_ready && !out_valid);

  assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_err) && $stable(out_volt));

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && in_ready));

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  assert_temp_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_volt |-> out_data >= TMIN && out_data <= TMAX);

  assert_zero_div_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> !out_volt && out_data == TMAX);
endmodule

bind sensor_code_conv sensor_code_conv_chk #(.OUT_W(OUT_W)) u_chk (.*);

// File: tb/sensor_code_conv_tb.sv
module sensor_code_conv_tb;
  localparam longint FHZ = 100000000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_volt = 1'b0, in_x2 = 1'b0, cfg_we = 1'b0, out_ready = 1'b0;
  logic [31:0] in_raw = '0, cfg_wdata = '0;
  logic [1:0]  cfg_addr = '0;
  logic in_ready, out_valid, out_volt, out_err;
  logic signed [31:0] out_data;
  logic in_ready_b, out_valid_b, out_volt_b, out_err_b;
  logic signed [31:0] out_data_b;

  int n_cmp = 0, n_bad = 0;
  longint mh = 200000, mg = 60000, mj = -100, mc = 4094;

  always #2 clk = ~clk;

  sensor_code_conv #(.IP_FREQ_HZ(100000000), .FAMILY_B(1'b0)) u_dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_raw, .in_volt, .in_x2,
    .cfg_we, .cfg_addr, .cfg_wdata, .out_valid, .out_ready,
    .out_data, .out_volt, .out_err);

  sensor_code_conv #(.IP_FREQ_HZ(100000000), .FAMILY_B(1'b1)) u_dut_b (
    .clk, .rst_n, .in_valid, .in_ready(in_ready_b), .in_raw, .in_volt, .in_x2,
    .cfg_we, .cfg_addr, .cfg_wdata, .out_valid(out_valid_b), .out_ready,
    .out_data(out_data_b), .out_volt(out_volt_b), .out_err(out_err_b));

  function automatic longint temp_model(longint n, longint h, longint g, longint j, longint c);
    longint t;
    if (c == 0) return 125000;
    t = g + (h * n) / c - h / 2 + (j * FHZ) / 1000000;
    if (t < -40000) t = -40000;
    if (t > 125000) t = 125000;
    return t;
  endfunction

  function automatic longint volt_model(longint n, bit x2);
    longint p = x2 ? 2 : 1;
    return p * (90 * n - 245805) / 1024;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      2'd0: mh = longint'(d);
      2'd1: mg = longint'(d);
      2'd2: mj = longint'($signed(d));
      default: mc = longint'(d);
    endcase
  endtask

  task automatic issue(logic [31:0] raw, bit volt, bit x2);
    @(negedge clk);
    chk("R9 in_ready before issue", longint'(in_ready), 1);
    in_raw = raw; in_volt = volt; in_x2 = x2; in_valid = 1'b1;
    @(posedge clk);
  endtask

  task automatic wait_out(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      in_valid = 1'b0;
      lat++;
    end while (!out_valid && lat < 400);
  endtask

  task automatic take();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R9 out_valid after take", longint'(out_valid), 0);
  endtask

  task automatic run_one(string req, logic [31:0] raw, bit volt, bit x2, bit check_lat);
    int lat;
    longint n = longint'(raw[15:0]);
    longint exp = volt ? volt_model(n, x2) : temp_model(n, mh, mg, mj, mc);
    bit e = !volt && mc == 0;
    issue(raw, volt, x2);
    wait_out(lat);
    chk(req, longint'(out_data), exp);
    chk({req, " err"}, longint'(out_err), longint'(e));
    chk("R9 out_volt", longint'(out_volt), longint'(volt));
    if (check_lat) chk("R10 latency", longint'(lat), (volt || e) ? 1 : 49);
    take();
  endtask

  initial begin
    int lat;
    longint e1;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    chk("R1 in_ready in reset", longint'(in_ready), 1);
    chk("R1 out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", longint'(out_valid), 0);

    // R5 both presets, n = 2048
    issue(32'd2048, 1'b0, 1'b0);
    wait_out(lat);
    chk("R5 family A preset", longint'(out_data), 50048);
    chk("R5 family B preset", longint'(out_data_b), 57400);
    chk("R10 temp latency", longint'(lat), 49);
    // R9 stall: held values
    repeat (3) begin
      @(negedge clk);
      chk("R9 held while stalled", longint'(out_data), 50048);
      chk("R9 valid while stalled", longint'(out_valid), 1);
    end
    take();

    run_one("R3 exact midpoint", 32'd2047, 1'b0, 1'b0, 1'b1);
    run_one("R4 low clamp", 32'd0, 1'b0, 1'b0, 1'b1);
    chk("R4 low clamp value", temp_model(0, mh, mg, mj, mc), -40000);
    run_one("R4 high clamp", 32'd65535, 1'b0, 1'b0, 1'b1);
    run_one("R2 upper bits ignored", 32'hABCD_07FF, 1'b0, 1'b0, 1'b1);
    run_one("R2 upper bits ignored volt", 32'hFFFF_0000, 1'b1, 1'b0, 1'b1);
    chk("R6 trunc toward zero", volt_model(0, 1'b0), -240);
    run_one("R6 zero code x1", 32'd0, 1'b1, 1'b0, 1'b1);
    run_one("R6 zero code x2", 32'd0, 1'b1, 1'b1, 1'b1);
    run_one("R6 full code x2", 32'd65535, 1'b1, 1'b1, 1'b1);
    run_one("R6 near zero", 32'd2731, 1'b1, 1'b0, 1'b1);

    // R7 write during conversion leaves in-flight sample alone
    e1 = temp_model(1000, mh, mg, mj, mc);
    issue(32'd1000, 1'b0, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    wr(2'd0, 32'd100000);
    wait_out(lat);
    chk("R7 in-flight uses old H", longint'(out_data), e1);
    take();
    run_one("R7 next sample uses new H", 32'd1000, 1'b0, 1'b0, 1'b1);
    wr(2'd1, 32'd10000);
    wr(2'd2, 32'hFFFF_FF00);
    run_one("R7 new G and J", 32'd3000, 1'b0, 1'b0, 1'b1);

    // R8 zero divisor
    wr(2'd3, 32'd0);
    run_one("R8 zero CAL5", 32'd1234, 1'b0, 1'b0, 1'b1);
    run_one("R8 voltage unaffected", 32'd5000, 1'b1, 1'b0, 1'b1);
    wr(2'd3, 32'd4000);
    run_one("R8 err clears", 32'd1234, 1'b0, 1'b0, 1'b1);

    // random mix (R3 R6 R7)
    for (int i = 0; i < 150; i++) begin
      if ($urandom_range(0, 4) == 0) begin
        case ($urandom_range(0, 3))
          0: wr(2'd0, $urandom_range(0, 400000));
          1: wr(2'd1, $urandom_range(0, 150000));
          2: wr(2'd2, 32'($signed($urandom_range(0, 400)) - 200));
          default: wr(2'd3, $urandom_range(1, 8192));
        endcase
      end
      if ($urandom_range(0, 1) == 0)
        run_one("R3 random temp", $urandom, 1'b0, 1'b0, 1'b1);
      else
        run_one("R6 random volt", $urandom, 1'b1, 1'($urandom_range(0, 1)), 1'b1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R9 watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule